// File: doc/BRIEF.md
# Alternate Bus Master Acquisition Controller

This block sits inside a device that wants to take over a shared bus from the current owner. The bus uses three handshake wires: a request, a grant and an acknowledge. Local logic raises `need_bus_i` when it has transfers to run. The controller then drives a request onto the bus and waits for a takeover window. It claims the bus by driving acknowledge, and it keeps that claim until local logic signals `done_i`.

The bus may be claimed only when four conditions hold at once:
- a grant has been received;
- the address strobe shows that no cycle is in progress;
- the termination line of the previous cycle has gone inactive;
- no other master is driving acknowledge.

The termination check can be removed with the `CHECK_TERM` parameter. All four shared inputs pass through a synchronizer of `SYNC_STAGES` flops before the state machine uses them. The flag `own_bus_o` tells local logic when it may start transfers.

All ports are active high. The `req_o` and `ack_o` outputs are the asserted levels of the bus wires. Pad drivers outside this block turn them into open-drain signals.

Top module: `busmaster_acquire`

## Requirements
- R1: While `rst_n` is low, and right after reset, `req_o`, `ack_o` and `own_bus_o` are all low.
- R2: `req_o` rises at the first clock edge after `need_bus_i` goes high. If `need_bus_i` falls before the bus is claimed, `req_o` falls at the next edge.
- R3: Without a grant (`grant_i` low), `ack_o` never rises, and `req_o` stays high while `need_bus_i` is high.
- R4: While `strobe_i` is high (cycle in progress), `ack_o` does not rise. Once `strobe_i` falls and the other conditions already hold, `ack_o` rises at the third clock edge after the fall.
- R5: With `CHECK_TERM=1`, `ack_o` does not rise while `term_i` is high. It rises at the third edge after `term_i` falls.
- R6: While `other_ack_i` is high, `ack_o` does not rise. It rises at the third edge after `other_ack_i` falls.
- R7: Suppose all other conditions hold and `need_bus_i` and `grant_i` rise together. Then `ack_o` rises at the fourth edge, and `req_o` falls at that same edge, so the two are never high together.
- R8: Once raised, `ack_o` stays high until `done_i` is seen high at a clock edge. `own_bus_o` equals `ack_o` at all times.
- R9: At the edge that samples `done_i` high, `ack_o` and `own_bus_o` fall. The block then goes idle with `req_o` low.
- R10: If the grant is withdrawn before the claim, the block goes back to requesting (`req_o` high, `ack_o` low). It claims only after a fresh grant, at the fourth edge after `grant_i` rises again.
- R11: With `CHECK_TERM=0`, `term_i` has no effect. The bus is claimed while `term_i` is high, with the same timing as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| need_bus_i | input | 1 | Local logic wants bus mastership |
| done_i | input | 1 | Local transfers finished; release the bus |
| grant_i | input | 1 | Bus grant from the arbiter (asynchronous) |
| strobe_i | input | 1 | Shared address strobe; high while a cycle is in progress (asynchronous) |
| term_i | input | 1 | Shared cycle termination; high while active (asynchronous) |
| other_ack_i | input | 1 | Acknowledge driven by another master (asynchronous) |
| req_o | output | 1 | Bus request level to drive |
| ack_o | output | 1 | Acknowledge level to drive; high for the whole tenure |
| own_bus_o | output | 1 | Local logic may run bus cycles |

## Verification
The bench builds two copies from the same stimulus. The first uses the defaults (`SYNC_STAGES=2`, `CHECK_TERM=1`); the second sets `CHECK_TERM=0`. The two-stage default fixes the exact latencies that the bench checks edge by edge. The second copy makes it possible to show that a claim is blocked by an active termination line in one build and allowed in the other.

// File: rtl/bma_pkg.sv
package bma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQUEST = 3'd1,
      ST_WAIT    = 3'd2,
      ST_OWN     = 3'd3,
      ST_RELEASE = 3'd4
   } bma_state_e;

   localparam int unsigned BMA_NUM_SHARED = 4;
endpackage

// File: rtl/bma_sync.sv
module bma_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   initial assert (STAGES >= 2) else $error("bma_sync: STAGES must be at least 2");

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= '0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/bma_qualify.sv
module bma_qualify #(
   parameter bit CHECK_TERM = 1'b1
) (
   input  logic grant_s,
   input  logic strobe_s,
   input  logic term_s,
   input  logic other_s,
   output logic take_ok
);
   logic term_clear;

   if (CHECK_TERM) begin : g_term_on
      assign term_clear = ~term_s;
   end else begin : g_term_off
      logic unused_term;
      assign unused_term = term_s;
      assign term_clear  = 1'b1 | unused_term;
   end

   assign take_ok = grant_s & ~strobe_s & term_clear & ~other_s;
endmodule

// File: rtl/bma_fsm.sv
module bma_fsm
   import bma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic need_bus,
   input  logic done,
   input  logic grant_s,
   input  logic take_ok,
   output logic req,
   output logic ack
);
   bma_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (need_bus) state_d = ST_REQUEST;
         ST_REQUEST: begin
            if (!need_bus)    state_d = ST_IDLE;
            else if (grant_s) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (!need_bus)     state_d = ST_IDLE;
            else if (!grant_s) state_d = ST_REQUEST;
            else if (take_ok)  state_d = ST_OWN;
         end
         ST_OWN:     if (done) state_d = ST_RELEASE;
         ST_RELEASE: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign req = (state_q == ST_REQUEST) || (state_q == ST_WAIT);
   assign ack = (state_q == ST_OWN);
endmodule

// File: rtl/busmaster_acquire.sv
module busmaster_acquire
   import bma_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          CHECK_TERM  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic need_bus_i,
   input  logic done_i,
   input  logic grant_i,
   input  logic strobe_i,
   input  logic term_i,
   input  logic other_ack_i,
   output logic req_o,
   output logic ack_o,
   output logic own_bus_o
);
   localparam int unsigned NSH = BMA_NUM_SHARED;

   initial assert (SYNC_STAGES >= 2) else $error("busmaster_acquire: SYNC_STAGES below 2");

   logic [NSH-1:0] shared_raw, shared_sync;
   logic grant_s, strobe_s, term_s, other_s, take_ok;

   assign shared_raw = {grant_i, strobe_i, term_i, other_ack_i};

   bma_sync #(.WIDTH(NSH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (shared_raw),
      .sync_o  (shared_sync)
   );

   assign {grant_s, strobe_s, term_s, other_s} = shared_sync;

   bma_qualify #(.CHECK_TERM(CHECK_TERM)) u_qual (
      .grant_s  (grant_s),
      .strobe_s (strobe_s),
      .term_s   (term_s),
      .other_s  (other_s),
      .take_ok  (take_ok)
   );

   bma_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .need_bus (need_bus_i),
      .done     (done_i),
      .grant_s  (grant_s),
      .take_ok  (take_ok),
      .req      (req_o),
      .ack      (ack_o)
   );

   assign own_bus_o = ack_o;
endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
   parameter bit CHECK_TERM = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic req_o,
   input logic ack_o,
   input logic done_i,
   input logic grant_s,
   input logic strobe_s,
   input logic term_s,
   input logic other_s
);
   p_req_ack_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_o && ack_o));

   p_claim_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(req_o));

   p_claim_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(grant_s));

   p_claim_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> !$past(strobe_s));

   p_claim_term_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> (!CHECK_TERM || !$past(term_s)));

   p_claim_no_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> !$past(other_s));

   p_hold_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> $past(done_i));

   p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> !req_o);
endmodule

bind busmaster_acquire bma_checker #(.CHECK_TERM(CHECK_TERM)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_o    (req_o),
   .ack_o    (ack_o),
   .done_i   (done_i),
   .grant_s  (grant_s),
   .strobe_s (strobe_s),
   .term_s   (term_s),
   .other_s  (other_s)
);

// File: tb/busmaster_acquire_bench.sv
`timescale 1ns/1ps
module busmaster_acquire_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic need_bus = 1'b0, done = 1'b0, grant = 1'b0;
   logic strobe = 1'b0, term = 1'b0, other = 1'b0;
   logic req, ack, own;
   logic req2, ack2, own2;
   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   busmaster_acquire u_busmaster_acquire (
      .clk(clk), .rst_n(rst_n), .need_bus_i(need_bus), .done_i(done),
      .grant_i(grant), .strobe_i(strobe), .term_i(term), .other_ack_i(other),
      .req_o(req), .ack_o(ack), .own_bus_o(own));

   busmaster_acquire #(.CHECK_TERM(1'b0)) u_busmaster_acquire_noterm (
      .clk(clk), .rst_n(rst_n), .need_bus_i(need_bus), .done_i(done),
      .grant_i(grant), .strobe_i(strobe), .term_i(term), .other_ack_i(other),
      .req_o(req2), .ack_o(ack2), .own_bus_o(own2));

   task automatic chk(input string tag, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_inputs();
      need_bus = 0; done = 0; grant = 0; strobe = 0; term = 0; other = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      clear_inputs();
      rst_n = 0;
      tick(3);
      rst_n = 1;
   endtask

   task automatic test_reset_r1();
      @(negedge clk);
      clear_inputs();
      rst_n = 0;
      need_bus = 1; grant = 1;
      tick(4);
      chk("R1 req in reset", req, 1'b0);
      chk("R1 ack in reset", ack, 1'b0);
      chk("R1 own in reset", own, 1'b0);
      rst_n = 1; clear_inputs();
      tick(1);
      chk("R1 req after reset", req, 1'b0);
   endtask

   task automatic test_request_r2();
      do_reset();
      need_bus = 1;
      tick(1);
      chk("R2 req raised", req, 1'b1);
      need_bus = 0;
      tick(1);
      chk("R2 req withdrawn", req, 1'b0);
      chk("R2 no ack", ack, 1'b0);
   endtask

   task automatic test_no_grant_r3();
      do_reset();
      need_bus = 1;
      tick(20);
      chk("R3 req held", req, 1'b1);
      chk("R3 no ack", ack, 1'b0);
   endtask

   task automatic test_claim_r7_r8_r9();
      do_reset();
      need_bus = 1; grant = 1;
      tick(3);
      chk("R7 no ack at edge 3", ack, 1'b0);
      chk("R7 req at edge 3", req, 1'b1);
      tick(1);
      chk("R7 ack at edge 4", ack, 1'b1);
      chk("R7 req drops with ack", req, 1'b0);
      need_bus = 0;
      tick(10);
      chk("R8 ack held", ack, 1'b1);
      chk("R8 own equals ack", own, 1'b1);
      done = 1;
      tick(1);
      chk("R9 ack released", ack, 1'b0);
      chk("R9 own released", own, 1'b0);
      done = 0; grant = 0;
      tick(2);
      chk("R9 idle req", req, 1'b0);
      chk("R9 idle ack", ack, 1'b0);
   endtask

   task automatic test_strobe_r4();
      do_reset();
      strobe = 1; need_bus = 1; grant = 1;
      tick(20);
      chk("R4 blocked by strobe", ack, 1'b0);
      chk("R4 req while blocked", req, 1'b1);
      strobe = 0;
      tick(2);
      chk("R4 ack not yet", ack, 1'b0);
      tick(1);
      chk("R4 ack after strobe idle", ack, 1'b1);
   endtask

   task automatic test_term_r5_r11();
      do_reset();
      term = 1; need_bus = 1; grant = 1;
      tick(4);
      chk("R11 claim ignoring term", ack2, 1'b1);
      tick(16);
      chk("R5 blocked by term", ack, 1'b0);
      chk("R11 still owns", own2, 1'b1);
      term = 0;
      tick(2);
      chk("R5 ack not yet", ack, 1'b0);
      tick(1);
      chk("R5 ack after term idle", ack, 1'b1);
   endtask

   task automatic test_other_r6();
      do_reset();
      other = 1; need_bus = 1; grant = 1;
      tick(20);
      chk("R6 blocked by other ack", ack, 1'b0);
      other = 0;
      tick(2);
      chk("R6 ack not yet", ack, 1'b0);
      tick(1);
      chk("R6 ack after other idle", ack, 1'b1);
   endtask

   task automatic test_grant_drop_r10();
      do_reset();
      strobe = 1; need_bus = 1; grant = 1;
      tick(10);
      grant = 0; strobe = 0;
      tick(20);
      chk("R10 no claim after grant loss", ack, 1'b0);
      chk("R10 back to requesting", req, 1'b1);
      grant = 1;
      tick(3);
      chk("R10 no ack at edge 3", ack, 1'b0);
      tick(1);
      chk("R10 ack at edge 4", ack, 1'b1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired (R1..): got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      test_reset_r1();
      test_request_r2();
      test_no_grant_r3();
      test_claim_r7_r8_r9();
      test_strobe_r4();
      test_term_r5_r11();
      test_other_r6();
      test_grant_drop_r10();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule